// File: doc/BRIEF.md
# Dual-Phase Coarse Timestamp Counter

This block produces the coarse part of a time-to-digital converter timestamp. Two 32-bit binary counters share one reference clock. One advances on the rising edge and the other on the falling edge, so they are half a period apart. Whenever one of them is changing, the other holds a settled value. A hit that freezes copies of both counters also records a fine code from the delay line. The fine code then chooses which copy to trust.

Each counter is built from 4-bit slices. Within a slice, the carry-out is formed directly from the slice's own state and its carry-in, so a long carry does not thread bit by bit through the word. Clearing is synchronous. The reset input is first registered on the rising edge, and the registered value then forces zeros into the counters' next-state logic. There is no load path.

The selection stage works as follows. A hit in the early half of the period (fine code below 16) takes the falling-edge copy. A hit in the late half takes the rising-edge copy. Both paths give the count of the most recent rising edge, so no correction is applied.

Top module: `coarse_stamp_top`

## Requirements
- R1: `riseCount` increases by exactly one on every rising clock edge at which the registered reset is low.
- R2: `fallCount` increases by exactly one on every falling clock edge at which the registered reset is low.
- R3: `rst` is sampled on a rising edge. The falling edge after that sample clears `fallCount` to 0, and the rising edge after that clears `riseCount` to 0. After release, `riseCount` still reads 0 after the first rising edge and reads 1 after the next one.
- R4: Outside reset, both counters hold the same value between a rising edge and the following falling edge. Between a falling edge and the next rising edge, `fallCount` equals `riseCount` + 1, modulo 2^32.
- R5: The count is correct across 4-bit slice boundaries, for example 0x0F is followed by 0x10.
- R6: After all ones, a counter returns to zero and raises no flag.
- R7: When `fineCode` is 0 to 15 (bit 4 clear), `stamp` equals `fallSnap`.
- R8: When `fineCode` is 16 to 31 (bit 4 set), `stamp` equals `riseSnap`.
- R9: The snapshot that is not selected has no effect on `stamp`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock; both edges are used |
| rst | input | 1 | Synchronous clear request, active high |
| riseSnap | input | 32 | Hit-time copy of the rising-edge counter |
| fallSnap | input | 32 | Hit-time copy of the falling-edge counter |
| fineCode | input | 5 | Delay-line tap index of the hit, 0 to 31 |
| riseCount | output | 32 | Live rising-edge counter |
| fallCount | output | 32 | Live falling-edge counter |
| stamp | output | 32 | Selected coarse timestamp |

## Verification
A hit can fall in the same cycle in which one of the two counters is stepping, and the selection must then avoid that counter. The bench places hits at the centre of each of the 32 tap positions within a period. At each hit it freezes the live counters and deliberately corrupts the copy that should be rejected. Each stamp is judged against a behavioural count of rising edges since reset. The counting itself is compared against that model at both clock phases, including across a wrap of a narrow instance and a reset issued mid-run.

// File: rtl/coarse_stamp_pkg.sv
package coarse_stamp_pkg;
  localparam int SLICE_W = 4;

  // Clear strobes issued by control, one per counter phase
  typedef struct packed {
    logic clearRise;
    logic clearFall;
  } clear_strobe_t;
endpackage

// File: rtl/coarse_slice.sv
module coarse_slice #(
  parameter int SW = 4
) (
  input  logic [SW-1:0] cur,
  input  logic          carryIn,
  input  logic          clear,
  output logic [SW-1:0] nxt,
  output logic          carryOut
);
  logic [SW:0] run;

  assign run[0] = carryIn;

  genvar i;
  generate
    for (i = 0; i < SW; i++) begin : g_bit
      assign run[i+1] = run[i] & cur[i];
      // clear goes through the data input, not a set/reset pin
      assign nxt[i]   = ~clear & (cur[i] ^ run[i]);
    end
  endgenerate

  // look-ahead: carry out from own state plus carry in
  assign carryOut = carryIn & (&cur);
endmodule

// File: rtl/coarse_counter.sv
module coarse_counter
  import coarse_stamp_pkg::*;
#(
  parameter int WIDTH  = 32,
  parameter bit RISING = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  output logic [WIDTH-1:0] count
);
  localparam int SLICES = WIDTH / SLICE_W;

  logic [WIDTH-1:0] countQ;
  logic [WIDTH-1:0] countD;
  logic [SLICES:0]  sliceCarry;

  assign sliceCarry[0] = 1'b1;

  genvar s;
  generate
    for (s = 0; s < SLICES; s++) begin : g_slice
      coarse_slice #(.SW(SLICE_W)) uSlice (
        .cur      (countQ[s*SLICE_W +: SLICE_W]),
        .carryIn  (sliceCarry[s]),
        .clear    (clear),
        .nxt      (countD[s*SLICE_W +: SLICE_W]),
        .carryOut (sliceCarry[s+1])
      );
    end

    if (RISING) begin : g_rise
      always_ff @(posedge clk) countQ <= countD;

      // R1
      rise_step_chk: assert property (@(posedge clk) disable iff (rst)
        !clear |=> countQ == WIDTH'($past(countQ) + 1'b1));
      // R3
      rise_clear_chk: assert property (@(posedge clk) disable iff (rst)
        clear |=> countQ == '0);
      // R6
      rise_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (!clear && (&countQ)) |=> countQ == '0);
    end else begin : g_fall
      always_ff @(negedge clk) countQ <= countD;

      // R2
      fall_step_chk: assert property (@(negedge clk) disable iff (rst)
        !clear |=> countQ == WIDTH'($past(countQ) + 1'b1));
      // R3
      fall_clear_chk: assert property (@(negedge clk) disable iff (rst)
        clear |=> countQ == '0);
      // R6
      fall_wrap_chk: assert property (@(negedge clk) disable iff (rst)
        (!clear && (&countQ)) |=> countQ == '0);
    end
  endgenerate

  assign count = countQ;
endmodule

// File: rtl/coarse_stamp_ctrl.sv
module coarse_stamp_ctrl
  import coarse_stamp_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  output clear_strobe_t stb
);
  logic rstQ;

  // reset is latched with the rising edge before it reaches any counter
  always_ff @(posedge clk) rstQ <= rst;

  always_comb begin
    stb.clearRise = rstQ;
    stb.clearFall = rstQ;
  end
endmodule

// File: rtl/coarse_stamp_dp.sv
module coarse_stamp_dp
  import coarse_stamp_pkg::*;
#(
  parameter int WIDTH  = 32,
  parameter int FINE_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  clear_strobe_t     stb,
  input  logic [WIDTH-1:0]  riseSnap,
  input  logic [WIDTH-1:0]  fallSnap,
  input  logic [FINE_W-1:0] fineCode,
  output logic [WIDTH-1:0]  riseCount,
  output logic [WIDTH-1:0]  fallCount,
  output logic [WIDTH-1:0]  stamp
);
  localparam int HALF_TAPS = 1 << (FINE_W - 1);

  logic lateHalf;

  coarse_counter #(.WIDTH(WIDTH), .RISING(1'b1)) uRise (
    .clk   (clk),
    .rst   (rst),
    .clear (stb.clearRise),
    .count (riseCount)
  );

  coarse_counter #(.WIDTH(WIDTH), .RISING(1'b0)) uFall (
    .clk   (clk),
    .rst   (rst),
    .clear (stb.clearFall),
    .count (fallCount)
  );

  // early-half hit: rising counter may be settling, trust the falling copy
  assign lateHalf = (32'(fineCode) >= HALF_TAPS);
  assign stamp    = lateHalf ? riseSnap : fallSnap;

  // R4
  early_align_chk: assert property (@(negedge clk) disable iff (rst || stb.clearRise)
    fallCount == riseCount);
  // R4
  late_lead_chk: assert property (@(posedge clk) disable iff (rst || stb.clearRise)
    fallCount == WIDTH'(riseCount + 1'b1));
endmodule

// File: rtl/coarse_stamp_top.sv
module coarse_stamp_top
  import coarse_stamp_pkg::*;
#(
  parameter int WIDTH  = 32,
  parameter int FINE_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [WIDTH-1:0]  riseSnap,
  input  logic [WIDTH-1:0]  fallSnap,
  input  logic [FINE_W-1:0] fineCode,
  output logic [WIDTH-1:0]  riseCount,
  output logic [WIDTH-1:0]  fallCount,
  output logic [WIDTH-1:0]  stamp
);
  clear_strobe_t stb;

  coarse_stamp_ctrl uCtrl (
    .clk (clk),
    .rst (rst),
    .stb (stb)
  );

  coarse_stamp_dp #(.WIDTH(WIDTH), .FINE_W(FINE_W)) uDp (
    .clk       (clk),
    .rst       (rst),
    .stb       (stb),
    .riseSnap  (riseSnap),
    .fallSnap  (fallSnap),
    .fineCode  (fineCode),
    .riseCount (riseCount),
    .fallCount (fallCount),
    .stamp     (stamp)
  );
endmodule

// File: tb/coarse_stamp_top_test.sv
module coarse_stamp_top_test;
  timeunit 1ns;
  timeprecision 1ps;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] riseSnap = '0;
  logic [31:0] fallSnap = '0;
  logic [4:0]  fineCode = '0;
  logic [31:0] riseCount, fallCount, stamp;

  logic [7:0]  nRiseCount, nFallCount, nStamp;

  int  checks = 0;
  int  errors = 0;
  bit  checkOn = 1'b0;
  bit  finished = 1'b0;

  // behavioural reference
  bit     rstM = 1'b1;
  longint riseM = 0, fallM = 0, nRiseM = 0, nFallM = 0;

  coarse_stamp_top uut (
    .clk(clk), .rst(rst), .riseSnap(riseSnap), .fallSnap(fallSnap),
    .fineCode(fineCode), .riseCount(riseCount), .fallCount(fallCount),
    .stamp(stamp)
  );

  coarse_stamp_top #(.WIDTH(8)) uutNarrow (
    .clk(clk), .rst(rst), .riseSnap(8'h00), .fallSnap(8'h00),
    .fineCode(5'd0), .riseCount(nRiseCount), .fallCount(nFallCount),
    .stamp(nStamp)
  );

  always #2 clk = ~clk;   // 250 MHz

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s at %0t: actual=%0h expected=%0h", tag, $time, act, exp);
    end
  endtask

  always @(posedge clk) begin
    rstM   <= rst;
    riseM  <= rstM ? 0 : ((riseM + 1) & 64'hFFFF_FFFF);
    nRiseM <= rstM ? 0 : ((nRiseM + 1) & 64'hFF);
  end

  always @(negedge clk) begin
    fallM  <= rstM ? 0 : ((fallM + 1) & 64'hFFFF_FFFF);
    nFallM <= rstM ? 0 : ((nFallM + 1) & 64'hFF);
  end

  // early half of each period
  always @(posedge clk) begin
    #1;
    if (checkOn) begin
      check(64'(riseCount) == riseM, "R1", riseCount, riseM);
      check(64'(fallCount) == fallM, "R2", fallCount, fallM);
      check(fallCount == riseCount, "R4", fallCount, riseCount);
      check(64'(nRiseCount) == nRiseM, "R5", nRiseCount, nRiseM);
      check(64'(nFallCount) == nFallM, "R5", nFallCount, nFallM);
    end
  end

  // late half of each period
  always @(negedge clk) begin
    #1;
    if (checkOn) begin
      check(64'(riseCount) == riseM, "R1", riseCount, riseM);
      check(64'(fallCount) == fallM, "R2", fallCount, fallM);
      if (!rstM)
        check(fallCount == riseCount + 32'd1, "R4", fallCount, riseCount + 32'd1);
      check(64'(nRiseCount) == nRiseM, "R5", nRiseCount, nRiseM);
      check(64'(nFallCount) == nFallM, "R5", nFallCount, nFallM);
    end
  end

  task automatic hitAt(input int p);
    logic [31:0] expStamp;
    @(posedge clk);
    #(p * 0.125 + 0.0625);
    expStamp = riseM[31:0];
    fineCode = 5'(p);
    if (p < 16) begin
      fallSnap = fallCount;
      riseSnap = ~riseCount ^ 32'h0F0F_0F0F;   // unsafe copy, corrupted
    end else begin
      riseSnap = riseCount;
      fallSnap = ~fallCount ^ 32'h3C3C_3C3C;
    end
    #0.01;
    if (p < 16) check(stamp == expStamp, "R7", stamp, expStamp);
    else        check(stamp == expStamp, "R8", stamp, expStamp);
    if (p < 16) riseSnap = riseSnap + 32'h1357;
    else        fallSnap = fallSnap ^ 32'hFFFF_0000;
    #0.01;
    check(stamp == expStamp, "R9", stamp, expStamp);
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    logic [31:0] held;
    logic [7:0]  nPrev;
    logic [31:0] wPrev;
    bit          sawWrap;
    sawWrap = 1'b0;

    repeat (4) @(posedge clk);
    #1;
    checkOn = 1'b1;
    check(riseCount == 0, "R3", riseCount, 0);
    check(fallCount == 0, "R3", fallCount, 0);

    // release and exact timing
    @(negedge clk); #1 rst = 1'b0;
    @(posedge clk); #1.5 check(riseCount == 0, "R3", riseCount, 0);
    @(negedge clk); #1.5 check(fallCount == 1, "R3", fallCount, 1);
    @(posedge clk); #1.5 check(riseCount == 1, "R3", riseCount, 1);

    // long run: slice carries and narrow wrap
    nPrev = nRiseCount;
    wPrev = riseCount;
    for (int c = 0; c < 300; c++) begin
      @(posedge clk); #1.5;
      if (nPrev == 8'h0F) check(nRiseCount == 8'h10, "R5", nRiseCount, 8'h10);
      if (wPrev == 32'h0F) check(riseCount == 32'h10, "R5", riseCount, 32'h10);
      if (nPrev == 8'hFF) begin
        check(nRiseCount == 8'h00, "R6", nRiseCount, 0);
        sawWrap = 1'b1;
      end
      nPrev = nRiseCount;
      wPrev = riseCount;
    end
    check(sawWrap, "R6", sawWrap, 1);

    for (int p = 0; p < 32; p++) hitAt(p);

    // reset during counting
    @(negedge clk); #1 rst = 1'b1;
    held = riseCount;
    @(posedge clk); #1.5 check(riseCount == held + 32'd1, "R3", riseCount, held + 32'd1);
    @(negedge clk); #1.5 check(fallCount == 0, "R3", fallCount, 0);
    @(posedge clk); #1.5 check(riseCount == 0, "R3", riseCount, 0);
    repeat (2) @(posedge clk);
    @(negedge clk); #1 rst = 1'b0;
    repeat (40) @(posedge clk);

    for (int p = 31; p >= 0; p--) hitAt(p);

    repeat (3) @(posedge clk);
    finished = 1'b1;
    summary();
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=running expected=complete");
      summary();
      $finish;
    end
  end
endmodule